// File: doc/BRIEF.md
# Baud Divisor Register Block

This block keeps a 12-bit baud divisor in two byte-wide registers and turns the system clock into the timing enables a serial port needs. The low byte has its own write address. The upper four bits sit behind an address that is also used by a control register. Bit 7 of each byte written to that address picks which of the two is updated.

A down-counter runs from the divisor value to zero. Each time it passes zero it gives a one-cycle sample enable, which is the oversampling tick. A second counter divides the sample enables by 16, or by 8 when double speed is on, and gives the bit-rate enable. A write to the low byte reloads the down-counter at once. A write to the high bits takes effect only at the next natural reload. Changing the divisor in the middle of a frame is allowed, but that frame may be damaged.

Top module: `baud_prescaler_if`

## Requirements
- R1: A write with `wr_addr_i`=0 stores `wr_data_i` as divisor bits 7:0, and `rd_sel_i`=0 reads that byte back.
- R2: A write with `wr_addr_i`=1 and `wr_data_i[7]`=0 stores `wr_data_i[3:0]` as divisor bits 11:8. A write with `wr_addr_i`=1 and `wr_data_i[7]`=1 stores the whole byte in the control register, which is read with `rd_sel_i`=2, and leaves the divisor and the tick period unchanged.
- R3: `rd_sel_i`=1 returns divisor bits 11:8 in bits 3:0 of `rd_data_o`, with zeros in bits 7:4. `rd_sel_i`=3 returns zero.
- R4: A low-byte write reloads the down-counter with the new divisor D. The first sample enable comes D+1 cycles after the write edge.
- R5: With double speed off, `sample_en_o` pulses for one cycle every D+1 cycles. `bit_en_o` pulses on one sample enable in every 16, which gives a bit period of 16·(D+1) cycles.
- R6: With double speed on, `bit_en_o` pulses on one sample enable in every 8. `bit_en_o` is never high unless `sample_en_o` is high.
- R7: After reset all registers read zero and both enables are low. With the divisor at zero, a sample enable follows every cycle.
- R8: A write to the divisor high bits does not restart the running count. The tick already pending arrives on its original schedule, and the new divisor applies from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 1 | 0: low divisor byte, 1: shared high/control address |
| wr_data_i | input | 8 | Write data; bit 7 selects the target at the shared address |
| rd_sel_i | input | 2 | Read select: 0 low, 1 high, 2 control, 3 none |
| rd_data_o | output | 8 | Read data for the selected register |
| dbl_speed_i | input | 1 | Double speed: divide sample enables by 8 instead of 16 |
| sample_en_o | output | 1 | Oversampling tick, one cycle wide |
| bit_en_o | output | 1 | Bit-rate tick, one cycle wide |

## Verification
The assertions assume that reset is held low for at least one clock edge, so that every `$past` value comes from the reset state. They also assume that `dbl_speed_i` is steady while a bit period is being measured. The stimulus changes `dbl_speed_i` only between measurements. Random divisor values are kept small, with one directed case that uses the high bits, so that each measured bit period stays to a few thousand cycles.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    RD_LOW  = 2'd0,
    RD_HIGH = 2'd1,
    RD_CTRL = 2'd2,
    RD_NONE = 2'd3
  } rd_sel_e;

  localparam int unsigned TGT_BIT = 7;  // selects high divisor vs control at shared address
endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import baud_pkg::*;
#(
  parameter int unsigned DIV_W  = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              load_o,
  output logic [DIV_W-1:0]  load_val_o
);
  localparam int unsigned HI_W = DIV_W - DATA_W;

  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [DATA_W-1:0] ctrl_q;
  logic              wr_lo, wr_hi, wr_ctrl;

  assign wr_lo   = wr_en_i && !wr_addr_i;
  assign wr_hi   = wr_en_i &&  wr_addr_i && !wr_data_i[TGT_BIT];
  assign wr_ctrl = wr_en_i &&  wr_addr_i &&  wr_data_i[TGT_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_lo)   lo_q   <= wr_data_i;
      if (wr_hi)   hi_q   <= wr_data_i[HI_W-1:0];
      if (wr_ctrl) ctrl_q <= wr_data_i;
    end
  end

  assign div_o      = {hi_q, lo_q};
  assign load_o     = wr_lo;
  assign load_val_o = {hi_q, wr_data_i};

  always_comb begin
    unique case (rd_sel_e'(rd_sel_i))
      RD_LOW:  rd_data_o = lo_q;
      RD_HIGH: rd_data_o = {{(DATA_W-HI_W){1'b0}}, hi_q};
      RD_CTRL: rd_data_o = ctrl_q;
      default: rd_data_o = '0;
    endcase
  end

  AST_LOW_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_addr_i) |=> div_o[DATA_W-1:0] == $past(wr_data_i)); // R1
  AST_CTRL_KEEPS_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i && wr_data_i[TGT_BIT]) |=> div_o == $past(div_o)); // R2
  AST_HI_RD_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == 2'd1) |-> rd_data_o[DATA_W-1:HI_W] == '0); // R3
endmodule

// File: rtl/baud_counter.sv
module baud_counter #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] load_val_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= load_val_i;
      tick_o <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q  <= div_i;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
      tick_o <= 1'b0;
    end
  end

  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)) && !tick_o); // R4
  AST_TICK_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> tick_o && cnt_q == $past(div_i)); // R5
  AST_NO_EARLY_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> !tick_o); // R8
endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div #(
  parameter int unsigned OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic dbl_i,
  output logic bit_en_o
);
  localparam int unsigned SUB_W = $clog2(OVS);

  logic [SUB_W-1:0] sub_q;
  logic             full_wrap, half_wrap;

  assign full_wrap = &sub_q;
  assign half_wrap = &sub_q[SUB_W-2:0];
  assign bit_en_o  = tick_i && (dbl_i ? half_wrap : full_wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sub_q <= '0;
    else if (tick_i) sub_q <= sub_q + 1'b1;
  end

  AST_BIT_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_o |-> tick_i); // R6
  AST_SUB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sub_q)); // R5
endmodule

// File: rtl/baud_prescaler_if.sv
module baud_prescaler_if #(
  parameter int unsigned DIV_W  = 12,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              dbl_speed_i,
  output logic              sample_en_o,
  output logic              bit_en_o
);
  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] load_val;
  logic             load;

  baud_regs #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_sel_i, .rd_data_o,
    .div_o(div), .load_o(load), .load_val_o(load_val)
  );

  baud_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk_i, .rst_ni, .div_i(div), .load_i(load), .load_val_i(load_val),
    .tick_o(sample_en_o)
  );

  baud_bit_div #(.OVS(OVS)) u_bit (
    .clk_i, .rst_ni, .tick_i(sample_en_o), .dbl_i(dbl_speed_i), .bit_en_o
  );
endmodule

// File: tb/baud_prescaler_if_test.sv
module baud_prescaler_if_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic       wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] rd_sel = 0;
  logic [7:0] rd_data;
  logic       dbl = 0;
  logic       sample_en, bit_en;

  int checks = 0;
  int fails  = 0;
  logic [7:0] m_lo = 0, m_ctrl = 0;
  logic [3:0] m_hi = 0;

  always #10 clk = ~clk;

  baud_prescaler_if uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .dbl_speed_i(dbl), .sample_en_o(sample_en), .bit_en_o(bit_en)
  );

  function automatic int exp_period(input logic [3:0] hi, input logic [7:0] lo);
    return int'({hi, lo}) + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    if (!a) m_lo = d;
    else if (!d[7]) m_hi = d[3:0];
    else m_ctrl = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    rd_sel = s;
    #1 v = rd_data;
  endtask

  task automatic next_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sample_en && n < 20000);
  endtask

  task automatic bit_ratio(output int k);
    int n;
    do next_tick(n); while (!bit_en);
    k = 0;
    do begin
      next_tick(n);
      k++;
    end while (!bit_en && k < 64);
  endtask

  task automatic period_test(input logic [3:0] hi, input logic [7:0] lo, input logic d2);
    int n, k, p;
    dbl = d2;
    wr(1'b1, {4'h0, hi});
    wr(1'b0, lo);
    p = exp_period(hi, lo);
    next_tick(n);
    check(n == p, "R4 first tick after reload", n, p);
    next_tick(n);
    check(n == p, "R5 tick interval", n, p);
    bit_ratio(k);
    if (d2) check(k == 8, "R6 ticks per bit double", k, 8);
    else    check(k == 16, "R5 ticks per bit normal", k, 16);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n, k;
    int unsigned seed;
    seed = $urandom(32'd2024);

    // R7 reset state
    #5;
    check(sample_en == 0 && bit_en == 0, "R7 enables low in reset", sample_en, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(2'd0, v); check(v == 0, "R7 low reads zero", v, 0);
    rd(2'd1, v); check(v == 0, "R7 high reads zero", v, 0);
    rd(2'd2, v); check(v == 0, "R7 control reads zero", v, 0);
    @(negedge clk);
    next_tick(n);
    check(n == 1, "R7 tick each cycle at divisor zero", n, 1);
    next_tick(n);
    check(n == 1, "R7 tick each cycle at divisor zero", n, 1);

    // R1 R2 R3 random register traffic
    for (int i = 0; i < 30; i++) begin
      logic a;
      logic [7:0] d;
      a = 1'($urandom);
      d = 8'($urandom);
      wr(a, d);
      rd(2'd0, v); check(v == m_lo, "R1 low readback", v, m_lo);
      rd(2'd1, v); check(v == {4'h0, m_hi}, "R3 high readback padded", v, {4'h0, m_hi});
      rd(2'd2, v); check(v == m_ctrl, "R2 control readback", v, m_ctrl);
      rd(2'd3, v); check(v == 0, "R3 unused select reads zero", v, 0);
    end

    // R4 R5 R6 directed corners and random divisors
    period_test(4'h0, 8'h00, 1'b0);
    period_test(4'h0, 8'h00, 1'b1);
    for (int i = 0; i < 6; i++) period_test(4'h0, 8'($urandom_range(1, 15)), 1'($urandom));
    period_test(4'h1, 8'h03, 1'b0);

    // R2 control write keeps divisor and period
    dbl = 0;
    wr(1'b1, 8'h00);
    wr(1'b0, 8'd6);
    next_tick(n);
    wr(1'b1, 8'hA5);
    rd(2'd2, v); check(v == 8'hA5, "R2 control stored", v, 8'hA5);
    rd(2'd0, v); check(v == 8'd6, "R2 low untouched by control write", v, 6);
    rd(2'd1, v); check(v == 0, "R2 high untouched by control write", v, 0);
    next_tick(n); next_tick(n);
    check(n == 7, "R2 period unchanged after control write", n, 7);

    // R8 high write mid-count does not reload
    wr(1'b1, 8'h00);
    wr(1'b0, 8'd40);
    repeat (10) @(negedge clk);
    wr(1'b1, 8'h01);
    next_tick(n);
    check(n == 29, "R8 pending tick keeps schedule", n, 29);
    next_tick(n);
    check(n == 297, "R8 new divisor at next reload", n, 297);

    // R6 bit enable only with sample enable
    dbl = 1;
    wr(1'b1, 8'h00);
    wr(1'b0, 8'd2);
    k = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (bit_en && !sample_en) k++;
    end
    check(k == 0, "R6 bit enable without sample enable", k, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule